// File: doc/BRIEF.md
# Block Copy Sequencer

This block performs a byte-by-byte memory-to-memory copy under control of three index registers. A start pulse captures a pair of bank numbers, a direction flag and initial values for the source index, the destination index and a count. The block then alternates one read from the source location and one write of that byte to the destination location over a single memory port with a ready handshake. It repeats this until the count runs out.

The count register holds one less than the number of bytes to copy. Each completed byte is one step. At the end of a step the indices move one position up or down, and the count drops by one. The step is marked by a single-cycle pulse. A companion pulse asks the surrounding sequencer to re-issue the copy operation while bytes remain. When the count wraps from zero to all-ones, a completion pulse fires and the block goes idle. The destination bank number is placed in the data-bank output on start, because the copy leaves that register pointing at the target bank.

Top module: `blkmv_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_req`, `step_done`, `rewind` and `done` are low, and `x_out`, `y_out`, `a_out` and `db_out` are zero.
- R2: A `start` pulse while idle captures the operands. The destination bank is `bank_pair[BANK_W-1:0]` and the source bank is `bank_pair[2*BANK_W-1:BANK_W]`. `db_out` takes the destination bank. A `start` seen while `busy` is ignored.
- R3: Every read request has `mem_we`=0 and `mem_addr` = {source bank, X}.
- R4: Every write request has `mem_we`=1, `mem_addr` = {`db_out`, Y}, and `mem_wdata` equal to the byte returned by the immediately preceding read.
- R5: A starting count of N copies exactly N+1 bytes. N=0 copies one byte.
- R6: With `desc_mode`=0, X and Y each increase by one after every byte. With `desc_mode`=1 they each decrease by one. Both wrap within IDX_W bits and never change a bank number.
- R7: `a_out` decreases by one after every byte and ends at all-ones.
- R8: `step_done` pulses for one cycle after each byte. `rewind` pulses together with it only when bytes remain.
- R9: `done` pulses exactly once, together with the final `step_done`, in the same cycle `busy` returns low.
- R10: While `mem_req` is high and `mem_ready` is low, the request, address and write flag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a copy (taken only when idle) |
| desc_mode | input | 1 | 0 = ascending indices, 1 = descending |
| bank_pair | input | 2*BANK_W | Low half destination bank, high half source bank |
| x_in | input | IDX_W | Initial source index |
| y_in | input | IDX_W | Initial destination index |
| a_in | input | IDX_W | Byte total minus one |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | BANK_W+IDX_W | {bank, index} address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Access accepted this cycle |
| x_out | output | IDX_W | Current source index |
| y_out | output | IDX_W | Current destination index |
| a_out | output | IDX_W | Current count |
| db_out | output | BANK_W | Data bank register |
| busy | output | 1 | Copy in progress |
| step_done | output | 1 | One-cycle pulse after each byte |
| rewind | output | 1 | One-cycle pulse: re-issue the copy operation |
| done | output | 1 | One-cycle pulse on completion |

## Verification
The bench builds the block with IDX_W=4 and BANK_W=2, so the whole 64-byte address space fits in a bench memory. At that width every count from 0 to 15 can be swept in both directions. This makes index wrap-around inside a bank, the count wrap to all-ones, and copies where source and destination overlap in the same bank all reachable in a short run. Varying the memory wait states from zero to two exercises the held-request behaviour. A spurious start during a copy checks that a busy block ignores new operands.

// File: rtl/blkmv_pkg.sv
package blkmv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } blkmv_state_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } blkmv_dir_e;

    // Registered per-step event flags
    typedef struct packed {
        logic step;
        logic more;
        logic last;
    } blkmv_evt_t;

    // Strobes from the sequencer to the datapath
    typedef struct packed {
        logic load;
        logic capture;
        logic advance;
    } blkmv_ctl_t;

endpackage

// File: rtl/blkmv_fsm.sv
module blkmv_fsm
    import blkmv_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         mem_ready,
    input  logic         a_zero,
    output blkmv_state_e state,
    output blkmv_ctl_t   ctl,
    output blkmv_evt_t   evt
);

    blkmv_state_e state_d;

    always_comb begin
        ctl.load    = (state == ST_IDLE)  && start;
        ctl.capture = (state == ST_READ)  && mem_ready;
        ctl.advance = (state == ST_WRITE) && mem_ready;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  if (start)     state_d = ST_READ;
            ST_READ:  if (mem_ready) state_d = ST_WRITE;
            ST_WRITE: if (mem_ready) state_d = a_zero ? ST_IDLE : ST_READ;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            evt   <= '0;
        end else begin
            state    <= state_d;
            evt.step <= ctl.advance;
            evt.more <= ctl.advance && !a_zero;
            evt.last <= ctl.advance && a_zero;
        end
    end

endmodule

// File: rtl/blkmv_regs.sv
module blkmv_regs
    import blkmv_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  blkmv_ctl_t        ctl,
    input  logic              desc_mode,
    input  logic [2*BANK_W-1:0] bank_pair,
    input  logic [IDX_W-1:0]  x_in,
    input  logic [IDX_W-1:0]  y_in,
    input  logic [IDX_W-1:0]  a_in,
    output logic [BANK_W-1:0] sb_q,
    output logic [BANK_W-1:0] db_q,
    output logic [IDX_W-1:0]  x_q,
    output logic [IDX_W-1:0]  y_q,
    output logic [IDX_W-1:0]  a_q,
    output logic              a_zero
);

    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);
    localparam int NUM_IDX = 2;

    blkmv_dir_e       dir_q;
    logic [IDX_W-1:0] ld_val [NUM_IDX];
    logic [IDX_W-1:0] idx_val[NUM_IDX];

    assign ld_val[0] = x_in;
    assign ld_val[1] = y_in;

    // Source and destination index counters share one structure
    for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
        logic [IDX_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (ctl.load) begin
                q <= ld_val[g];
            end else if (ctl.advance) begin
                q <= (dir_q == DIR_DOWN) ? q - ONE : q + ONE;
            end
        end
        assign idx_val[g] = q;
    end

    assign x_q = idx_val[0];
    assign y_q = idx_val[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= DIR_UP;
            sb_q  <= '0;
            db_q  <= '0;
            a_q   <= '0;
        end else if (ctl.load) begin
            dir_q <= desc_mode ? DIR_DOWN : DIR_UP;
            db_q  <= bank_pair[BANK_W-1:0];
            sb_q  <= bank_pair[2*BANK_W-1:BANK_W];
            a_q   <= a_in;
        end else if (ctl.advance) begin
            a_q   <= a_q - ONE;
        end
    end

    assign a_zero = (a_q == '0);

endmodule

// File: rtl/blkmv_port.sv
module blkmv_port
    import blkmv_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int BANK_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  blkmv_state_e            state,
    input  blkmv_ctl_t              ctl,
    input  logic [BANK_W-1:0]       sb_q,
    input  logic [BANK_W-1:0]       db_q,
    input  logic [IDX_W-1:0]        x_q,
    input  logic [IDX_W-1:0]        y_q,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [BANK_W+IDX_W-1:0] mem_addr,
    output logic [DATA_W-1:0]       mem_wdata
);

    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (ctl.capture) begin
            hold_q <= mem_rdata;
        end
    end

    always_comb begin
        mem_req   = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_addr  = mem_we ? {db_q, y_q} : {sb_q, x_q};
        mem_wdata = hold_q;
    end

endmodule

// File: rtl/blkmv_ctrl.sv
module blkmv_ctrl
    import blkmv_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int BANK_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    desc_mode,
    input  logic [2*BANK_W-1:0]     bank_pair,
    input  logic [IDX_W-1:0]        x_in,
    input  logic [IDX_W-1:0]        y_in,
    input  logic [IDX_W-1:0]        a_in,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [BANK_W+IDX_W-1:0] mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    input  logic [DATA_W-1:0]       mem_rdata,
    input  logic                    mem_ready,
    output logic [IDX_W-1:0]        x_out,
    output logic [IDX_W-1:0]        y_out,
    output logic [IDX_W-1:0]        a_out,
    output logic [BANK_W-1:0]       db_out,
    output logic                    busy,
    output logic                    step_done,
    output logic                    rewind,
    output logic                    done
);

    blkmv_state_e      state;
    blkmv_ctl_t        ctl;
    blkmv_evt_t        evt;
    logic              a_zero;
    logic [BANK_W-1:0] sb_q;

    blkmv_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mem_ready (mem_ready),
        .a_zero    (a_zero),
        .state     (state),
        .ctl       (ctl),
        .evt       (evt)
    );

    blkmv_regs #(.IDX_W(IDX_W), .BANK_W(BANK_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .desc_mode (desc_mode),
        .bank_pair (bank_pair),
        .x_in      (x_in),
        .y_in      (y_in),
        .a_in      (a_in),
        .sb_q      (sb_q),
        .db_q      (db_out),
        .x_q       (x_out),
        .y_q       (y_out),
        .a_q       (a_out),
        .a_zero    (a_zero)
    );

    blkmv_port #(.IDX_W(IDX_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_port (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .ctl       (ctl),
        .sb_q      (sb_q),
        .db_q      (db_out),
        .x_q       (x_out),
        .y_q       (y_out),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    assign busy      = (state != ST_IDLE);
    assign step_done = evt.step;
    assign rewind    = evt.more;
    assign done      = evt.last;

endmodule

// File: rtl/blkmv_chk.sv
module blkmv_chk #(
    parameter int IDX_W  = 16,
    parameter int BANK_W = 8,
    parameter int DATA_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    mem_req,
    input logic                    mem_we,
    input logic [BANK_W+IDX_W-1:0] mem_addr,
    input logic                    mem_ready,
    input logic [IDX_W-1:0]        x_out,
    input logic [IDX_W-1:0]        y_out,
    input logic [IDX_W-1:0]        a_out,
    input logic [BANK_W-1:0]       db_out,
    input logic                    busy,
    input logic                    step_done,
    input logic                    rewind,
    input logic                    done
);

    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    assert_db_held_R2: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(db_out));

    assert_read_addr_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we |-> mem_addr[IDX_W-1:0] == x_out);

    assert_write_addr_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> mem_addr == {db_out, y_out});

    assert_index_step_R6: assert property (@(posedge clk) disable iff (rst)
        step_done |-> (x_out == $past(x_out) + ONE && y_out == $past(y_out) + ONE)
                   || (x_out == $past(x_out) - ONE && y_out == $past(y_out) - ONE));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        step_done |-> a_out == $past(a_out) - ONE);

    assert_rewind_in_step_R8: assert property (@(posedge clk) disable iff (rst)
        rewind |-> step_done && busy);

    assert_done_final_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> step_done && !rewind && !busy && a_out == '1);

    assert_hold_request_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

endmodule

bind blkmv_ctrl blkmv_chk #(.IDX_W(IDX_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .x_out     (x_out),
    .y_out     (y_out),
    .a_out     (a_out),
    .db_out    (db_out),
    .busy      (busy),
    .step_done (step_done),
    .rewind    (rewind),
    .done      (done)
);

// File: tb/blkmv_ctrl_tb.sv
module blkmv_ctrl_tb;

    localparam int IW  = 4;
    localparam int BW  = 2;
    localparam int DW  = 8;
    localparam int AW  = BW + IW;
    localparam int MSZ = 1 << AW;
    localparam int IMASK = (1 << IW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          desc_mode = 1'b0;
    logic [2*BW-1:0] bank_pair = '0;
    logic [IW-1:0] x_in = '0, y_in = '0, a_in = '0;
    logic          mem_req, mem_we, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [IW-1:0] x_out, y_out, a_out;
    logic [BW-1:0] db_out;
    logic          busy, step_done, rewind, done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    blkmv_ctrl #(.IDX_W(IW), .BANK_W(BW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .start(start), .desc_mode(desc_mode),
        .bank_pair(bank_pair), .x_in(x_in), .y_in(y_in), .a_in(a_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .x_out(x_out), .y_out(y_out), .a_out(a_out), .db_out(db_out),
        .busy(busy), .step_done(step_done), .rewind(rewind), .done(done)
    );

    // Bench memory model with programmable wait states
    logic [DW-1:0] mem [MSZ];
    logic [1:0]    wcnt;
    int            lat = 0;
    logic          fill_req = 1'b0;
    int            fill_seed = 0;

    function automatic logic [DW-1:0] pat(int i, int s);
        return DW'(i * 37 + s * 11 + 5);
    endfunction

    assign mem_ready = mem_req && (int'(wcnt) >= lat);
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (rst || !mem_req || mem_ready) wcnt <= '0;
        else                              wcnt <= wcnt + 2'd1;
        if (fill_req) begin
            for (int i = 0; i < MSZ; i++) mem[i] <= pat(i, fill_seed);
        end else if (mem_req && mem_we && mem_ready) begin
            mem[mem_addr] <= mem_wdata;
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_move(bit dn, int sb, int db, int x, int y, int a, bit glitch);
        logic [DW-1:0] refm [MSZ];
        int steps = 0, rews = 0, dones = 0, n = 0, bad = 0, first_bad = -1;
        int ex, ey, d;
        @(negedge clk);
        fill_seed = sb * 7 + db * 3 + a + x;
        fill_req  = 1'b1;
        @(negedge clk);
        fill_req  = 1'b0;
        for (int i = 0; i < MSZ; i++) refm[i] = pat(i, fill_seed);
        d = dn ? -1 : 1;
        for (int k = 0; k <= a; k++) begin
            int sa = (sb << IW) | ((x + d * k) & IMASK);
            int da = (db << IW) | ((y + d * k) & IMASK);
            refm[da] = refm[sa];
        end
        desc_mode = dn;
        bank_pair = {BW'(sb), BW'(db)};
        x_in = IW'(x); y_in = IW'(y); a_in = IW'(a);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        forever begin
            n++;
            if (glitch && n == 3) begin
                start = 1'b1; desc_mode = ~dn;
                bank_pair = ~bank_pair; x_in = ~x_in; a_in = '0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            steps += int'(step_done);
            rews  += int'(rewind);
            dones += int'(done);
            if (!busy || n > 2000) break;
        end
        start = 1'b0;
        check(n <= 2000, "R9 busy falls", n, 2000);
        for (int i = 0; i < MSZ; i++)
            if (mem[i] !== refm[i]) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        check(bad == 0, "R3/R4/R5 memory image (mismatching bytes)", bad, 0);
        ex = (x + d * (a + 1)) & IMASK;
        ey = (y + d * (a + 1)) & IMASK;
        check(int'(x_out) == ex, "R6 final X", int'(x_out), ex);
        check(int'(y_out) == ey, "R6 final Y", int'(y_out), ey);
        check(int'(a_out) == IMASK, "R7 final count", int'(a_out), IMASK);
        check(int'(db_out) == db, "R2 data bank", int'(db_out), db);
        check(steps == a + 1, "R8 step pulses", steps, a + 1);
        check(rews == a, "R8 rewind pulses", rews, a);
        check(dones == 1, "R9 done pulses", dones, 1);
    endtask

    initial begin
        wait (cyc == 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(!busy && !mem_req, "R1 idle after reset", int'(busy), 0);
        check(!step_done && !rewind && !done, "R1 pulses low", int'(done), 0);
        check(a_out == '0 && x_out == '0 && y_out == '0, "R1 indices zero", int'(a_out), 0);
        check(db_out == '0, "R1 data bank zero", int'(db_out), 0);
        for (int dn = 0; dn < 2; dn++)
            for (int a = 0; a <= IMASK; a++)
                for (int cfg = 0; cfg < 2; cfg++) begin
                    lat = (a + cfg) % 3;
                    if (cfg == 0)
                        run_move(dn[0], 1, 2, (a * 3) & IMASK, IMASK - a, a, 1'b0);
                    else
                        run_move(dn[0], 3, 3, 5, dn ? 3 : 7, a, 1'b1);
                end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule